// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a segment selector and a 32-bit offset into a 32-bit linear address. It accepts one request at a time. It decodes the selector to find a descriptor in either the global table or the local table, and reads the 8-byte descriptor as two 32-bit words through a simple read port. It then checks the descriptor and returns either a linear address or a fault code.

The block runs three checks, always in the same order. First it checks that the segment is present. Next it checks the privilege: the current privilege level must be numerically no larger than the descriptor's level, where 0 is the most privileged level and 3 the least. Last it checks the offset against the segment limit. The base is added to the offset only when all three checks pass. A faulting response carries a zero address. On the first cycle that a faulting response is offered, a one-cycle strobe is raised with it.

The request side and the response side each use a valid/ready handshake. The memory side holds its read request until the memory answers with a data-valid pulse.

Top module: `seg_xlate_unit`

## Requirements
- R1: The selector index is in bits [15:3] and the table select is bit 2 (0 = global table, 1 = local table). Bits [1:0] are ignored. The low descriptor word is read at table base + index*8 and the high word at that address + 4.
- R2: The low descriptor word is the 32-bit segment base. In the high word, bit 31 is the present flag, bits 30:29 are the descriptor privilege level and bits 19:0 are the limit.
- R3: A request without a fault returns base + offset modulo 2^32 with fault code 0.
- R4: The limit check is inclusive. An offset larger than the zero-extended 20-bit limit gives fault code 3. An offset equal to the limit is legal.
- R5: When the current privilege level is numerically greater than the descriptor privilege level, the fault code is 2.
- R6: A descriptor whose present flag is clear gives fault code 1.
- R7: Fault priority is fixed: not-present (1) first, then privilege (2), then limit (3).
- R8: fault_strobe is high for exactly one cycle, the first cycle of a faulting response. A faulting response reports a linear address of zero.
- R9: req_ready is high only while the unit is idle. Selector, offset, privilege level and table bases are captured at acceptance. Input changes after that have no effect on the result.
- R10: mem_req stays high with a stable mem_addr until mem_rvalid is seen.
- R11: While rsp_valid is high and rsp_ready is low, the response fields stay stable.
- R12: While reset is asserted, req_ready is 1 and rsp_valid, mem_req and fault_strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The unit is idle and can take a request |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_cpl | input | 2 | Current privilege level |
| gdt_base | input | 32 | Base address of the global table |
| ldt_base | input | 32 | Base address of the local table |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| rsp_valid | output | 1 | A response is offered |
| rsp_ready | input | 1 | The response is taken |
| rsp_linear | output | 32 | Linear address, zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 privilege, 3 limit |
| fault_strobe | output | 1 | One-cycle pulse that marks a faulting response |

## Verification
The bench sweeps both tables, sixteen indices and all four privilege levels. The offsets it uses are zero, exactly the limit, one past the limit and all ones. Together these catch the following errors:
- An exclusive limit compare rejects the offset that equals the limit.
- A reversed privilege compare faults requests from level 0.
- A wrong priority order reports a limit or privilege code where not-present must win.

A base near the top of the address space checks that the add wraps modulo 2^32. Index 8191 checks that the top index bits reach the address. The bench scrambles the request inputs right after acceptance and holds off rsp_ready. A unit that reads the live inputs late returns a wrong address. A unit that repeats the strobe, or changes a held response, is caught directly. The memory model checks every address it serves and answers with varied latency, so a swapped or mis-scaled descriptor address is reported.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int SEGX_AW = 32;
  localparam int SEGX_LW = 20;
  localparam int SEGX_IW = 13;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_NOTPRES = 2'd1,
    FLT_PRIV    = 2'd2,
    FLT_LIMIT   = 2'd3
  } flt_e;

  typedef struct packed {
    logic               present;
    logic [1:0]         dpl;
    logic [SEGX_LW-1:0] limit;
    logic [SEGX_AW-1:0] base;
  } seg_desc_t;
endpackage

// File: rtl/segx_sel_decode.sv
module segx_sel_decode #(
  parameter int AW = segx_pkg::SEGX_AW,
  parameter int IW = segx_pkg::SEGX_IW
) (
  input  logic [15:0]   sel,
  input  logic [AW-1:0] gbl_base,
  input  logic [AW-1:0] lcl_base,
  output logic [AW-1:0] desc_addr
);
  localparam int SHIFT = 3;
  localparam int PAD   = AW - IW - SHIFT;

  logic [IW-1:0] idx;
  logic          tbl_local;
  logic [AW-1:0] tbl_base;
  logic [AW-1:0] idx_bytes;

  always_comb begin
    idx       = sel[SHIFT +: IW];
    tbl_local = sel[2];
    tbl_base  = tbl_local ? lcl_base : gbl_base;
    idx_bytes = {{PAD{1'b0}}, idx, {SHIFT{1'b0}}};
    desc_addr = tbl_base + idx_bytes;
  end
endmodule

// File: rtl/segx_desc_fetch.sv
module segx_desc_fetch #(
  parameter int AW = segx_pkg::SEGX_AW,
  parameter int LW = segx_pkg::SEGX_LW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       start_addr,
  input  logic                mem_rvalid,
  input  logic [AW-1:0]       mem_rdata,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  output logic                done,
  output segx_pkg::seg_desc_t desc_out
);
  import segx_pkg::*;

  localparam int            WORD_BYTES = AW / 8;
  localparam logic [AW-1:0] HI_STEP    = AW'(WORD_BYTES);

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;

  fst_e          st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;
  logic [AW-1:0] base_q;
  logic          base_en;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    base_en = 1'b0;
    case (st_q)
      F_IDLE: if (start) begin
        st_d    = F_LO;
        addr_d  = start_addr;
        addr_en = 1'b1;
      end
      F_LO: if (mem_rvalid) begin
        st_d    = F_HI;
        addr_d  = addr_q + HI_STEP;
        addr_en = 1'b1;
        base_en = 1'b1;
      end
      F_HI: if (mem_rvalid) st_d = F_IDLE;
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= F_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= mem_rdata;
  end

  always_comb begin
    mem_req          = (st_q != F_IDLE);
    mem_addr         = addr_q;
    done             = (st_q == F_HI) && mem_rvalid;
    desc_out.base    = base_q;
    desc_out.present = mem_rdata[AW-1];
    desc_out.dpl     = mem_rdata[AW-2 -: 2];
    desc_out.limit   = mem_rdata[LW-1:0];
  end

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  assert_hi_after_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_LO && mem_rvalid) |=> (mem_req && mem_addr == $past(mem_addr) + HI_STEP));
endmodule

// File: rtl/segx_check.sv
module segx_check #(
  parameter int AW = segx_pkg::SEGX_AW,
  parameter int LW = segx_pkg::SEGX_LW
) (
  input  segx_pkg::seg_desc_t desc,
  input  logic [AW-1:0]       off,
  input  logic [1:0]          cpl,
  output logic [1:0]          code,
  output logic [AW-1:0]       linear
);
  import segx_pkg::*;

  logic [AW-1:0] lim_ext;
  logic          off_over;
  logic          priv_bad;
  logic [AW-1:0] sum;

  generate
    if (AW > LW) begin : g_ext
      assign lim_ext = {{(AW-LW){1'b0}}, desc.limit};
    end else begin : g_same
      assign lim_ext = desc.limit[AW-1:0];
    end
  endgenerate

  always_comb begin
    off_over = (off > lim_ext);
    priv_bad = (cpl > desc.dpl);
    sum      = desc.base + off;
    if (!desc.present)  code = FLT_NOTPRES;
    else if (priv_bad)  code = FLT_PRIV;
    else if (off_over)  code = FLT_LIMIT;
    else                code = FLT_NONE;
    linear = (code == FLT_NONE) ? sum : '0;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int AW = segx_pkg::SEGX_AW,
  parameter int LW = segx_pkg::SEGX_LW,
  parameter int IW = segx_pkg::SEGX_IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [15:0]   req_sel,
  input  logic [AW-1:0] req_off,
  input  logic [1:0]    req_cpl,
  input  logic [AW-1:0] gdt_base,
  input  logic [AW-1:0] ldt_base,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_linear,
  output logic [1:0]    rsp_fault,
  output logic          fault_strobe
);
  import segx_pkg::*;

  typedef enum logic [1:0] {T_IDLE, T_FETCH, T_RESP} tst_e;

  tst_e          st_q, st_d;
  logic          accept;
  logic          rsp_load;
  logic [AW-1:0] dec_addr;
  logic [AW-1:0] off_q;
  logic [1:0]    cpl_q;
  logic          fetch_done;
  seg_desc_t     desc;
  logic [1:0]    chk_code;
  logic [AW-1:0] chk_lin;
  logic [AW-1:0] lin_q;
  logic [1:0]    code_q;
  logic          strobe_d, strobe_q;

  segx_sel_decode #(.AW(AW), .IW(IW)) u_dec (
    .sel       (req_sel),
    .gbl_base  (gdt_base),
    .lcl_base  (ldt_base),
    .desc_addr (dec_addr)
  );

  segx_desc_fetch #(.AW(AW), .LW(LW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (dec_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .done       (fetch_done),
    .desc_out   (desc)
  );

  segx_check #(.AW(AW), .LW(LW)) u_chk (
    .desc   (desc),
    .off    (off_q),
    .cpl    (cpl_q),
    .code   (chk_code),
    .linear (chk_lin)
  );

  always_comb begin
    st_d     = st_q;
    accept   = 1'b0;
    rsp_load = 1'b0;
    case (st_q)
      T_IDLE: if (req_valid) begin
        accept = 1'b1;
        st_d   = T_FETCH;
      end
      T_FETCH: if (fetch_done) begin
        rsp_load = 1'b1;
        st_d     = T_RESP;
      end
      T_RESP: if (rsp_ready) st_d = T_IDLE;
      default: st_d = T_IDLE;
    endcase
    strobe_d = rsp_load && (chk_code != FLT_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= T_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      cpl_q <= '0;
    end else if (accept) begin
      off_q <= req_off;
      cpl_q <= req_cpl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q  <= '0;
      code_q <= FLT_NONE;
    end else if (rsp_load) begin
      lin_q  <= chk_lin;
      code_q <= chk_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  always_comb begin
    req_ready    = (st_q == T_IDLE);
    rsp_valid    = (st_q == T_RESP);
    rsp_linear   = lin_q;
    rsp_fault    = code_q;
    fault_strobe = strobe_q;
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_linear) && $stable(rsp_fault)));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_strobe |=> !fault_strobe);

  assert_strobe_with_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_strobe |-> (rsp_valid && rsp_fault != FLT_NONE && rsp_linear == '0));

  assert_one_at_a_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_req && !req_ready));

  assert_resp_after_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(mem_req && mem_rvalid));
endmodule

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GDT = 32'h0010_0000;
  localparam logic [31:0] LDT = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [1:0]  req_cpl = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_linear;
  logic [1:0]  rsp_fault;
  logic        fault_strobe;

  int total = 0;
  int fails = 0;
  int lat = 0;
  int cnt = 0;
  bit phase = 1'b0;
  logic [31:0] exp_daddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_off(req_off), .req_cpl(req_cpl),
    .gdt_base(GDT), .ldt_base(LDT),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_linear(rsp_linear), .rsp_fault(rsp_fault),
    .fault_strobe(fault_strobe)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] dbase(input bit t, input int idx);
    if (idx == 15) return 32'hFFFF_FF80;
    return 32'h0004_0000 * (32'(t) + 1) + 32'(idx) * 32'h0000_1010;
  endfunction
  function automatic bit dpres(input bit t, input int idx);
    return ((idx + int'(t)) % 5) != 3;
  endfunction
  function automatic logic [1:0] ddpl(input bit t, input int idx);
    return 2'((idx + 2 * int'(t)) % 4);
  endfunction
  function automatic logic [19:0] dlim(input int idx);
    return 20'(32'h40 + 32'(idx) * 8);
  endfunction

  // R2: memory image holds base in low word; present, level, limit in high word
  function automatic logic [31:0] memw(input logic [31:0] a);
    bit t = a[21];
    logic [31:0] tb = t ? LDT : GDT;
    int idx = int'((a - tb) >> 3);
    if (!a[2]) return dbase(t, idx);
    return {dpres(t, idx), ddpl(t, idx), 9'b0, dlim(idx)};
  endfunction

  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        chk(mem_addr == exp_daddr + (phase ? 32'd4 : 32'd0), "R1", mem_addr,
            exp_daddr + (phase ? 32'd4 : 32'd0));
        mem_rdata  = memw(mem_addr);
        mem_rvalid = 1'b1;
        phase      = ~phase;
      end else cnt++;
    end
  end

  task automatic run_req(input logic [15:0] sel, input logic [31:0] off, input logic [1:0] cpl,
                         input int lat_i, input bit stall);
    bit t = sel[2];
    int idx = int'(sel[15:3]);
    logic [1:0] ecode;
    logic [31:0] elin;
    int n = 0;
    logic [31:0] lin_s;
    logic [1:0] code_s;
    if (!dpres(t, idx))                           ecode = 2'd1;
    else if (cpl > ddpl(t, idx))                  ecode = 2'd2;
    else if (off > {12'b0, dlim(idx)})            ecode = 2'd3;
    else                                          ecode = 2'd0;
    elin = (ecode == 2'd0) ? dbase(t, idx) + off : 32'd0;
    exp_daddr = (t ? LDT : GDT) + 32'(idx) * 8;
    lat = lat_i;
    phase = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_off = off; req_cpl = cpl;
    @(negedge clk);
    req_valid = 1'b0; req_sel = ~sel; req_off = ~off; req_cpl = ~cpl;
    chk(req_ready == 1'b0, "R9", 32'(req_ready), 32'd0);
    while (!rsp_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, "R10", 32'(rsp_valid), 32'd1);
    chk(fault_strobe == (ecode != 2'd0), "R8", 32'(fault_strobe), 32'(ecode != 2'd0));
    lin_s = rsp_linear;
    code_s = rsp_fault;
    if (stall) begin
      @(negedge clk);
      chk(rsp_valid && rsp_linear == lin_s && rsp_fault == code_s, "R11", rsp_linear, lin_s);
      chk(fault_strobe == 1'b0, "R8", 32'(fault_strobe), 32'd0);
    end
    chk(rsp_fault == ecode, ecode == 2'd1 ? "R6" : ecode == 2'd2 ? "R5" : ecode == 2'd3 ? "R4" : "R7",
        32'(rsp_fault), 32'(ecode));
    chk(rsp_linear == elin, ecode == 2'd0 ? "R3" : "R8", rsp_linear, elin);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9", 32'({rsp_valid, req_ready}), 32'b01);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R12: idle outputs under reset
    chk(req_ready && !rsp_valid && !mem_req && !fault_strobe, "R12",
        32'({req_ready, rsp_valid, mem_req, fault_strobe}), 32'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", 32'(req_ready), 32'd1);
    for (int t = 0; t < 2; t++)
      for (int idx = 0; idx < 16; idx++)
        for (int c = 0; c < 4; c++)
          for (int k = 0; k < 4; k++) begin
            logic [31:0] off;
            case (k)
              0: off = 32'd0;
              1: off = {12'b0, dlim(idx)};
              2: off = {12'b0, dlim(idx)} + 32'd1;
              default: off = 32'hFFFF_FFFF;
            endcase
            run_req({13'(idx), 1'(t), 2'(k)}, off, 2'(c), (idx + k) % 3, ((idx + c) % 3) == 0);
          end
    // top index in each table (R1)
    for (int t = 0; t < 2; t++) begin
      run_req({13'h1FFF, 1'(t), 2'b11}, 32'h0000_1000, 2'd0, 1, 1'b0);
      run_req({13'h1FFF, 1'(t), 2'b00}, {12'b0, dlim(8191)}, 2'd0, 0, 1'b1);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule